// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block picks the three divider settings of a clock synthesiser: an input divider M, a feedback multiplier N and a post divider PL. It is given a reference frequency and a requested output frequency, both in kHz. It returns the triple whose output lands nearest the request, with both the divided reference and the oscillator frequency kept inside their legal windows. It also reports the output frequency that the chosen triple actually yields, and a flag for the case where no legal triple exists.

A request is issued with a one-cycle `start` pulse. The engine then runs a pruned three-level search, with the post divider outermost, the input divider next and the feedback multiplier innermost. Every quotient comes from one shared restoring divider that needs a fixed number of cycles. `busy` stays high for the whole search and a one-cycle `done` marks the result. In exhaustive mode (`best_fit` = 1) only an exact hit ends the search early. In the relaxed mode (`best_fit` = 0) a close enough hit also ends it. Every limit is a parameter.

Top module: `pll_coef_search`

## Requirements
- R1: The requested frequency is clamped into [F_MIN, F_MAX] (default 128,000 to 2,600,000 kHz) before any other step. All later steps use the clamped value.
- R2: The oscillator goal is the request plus request/50 (integer division). The oscillator ceiling is the larger of VCO_MAX and that goal. PL runs upward from floor(VCO_MIN/goal) to ceil(ceiling/goal), and each bound is first clamped into [PL_MIN, PL_MAX] (default 1 to 31). The divide ratio equals PL.
- R3: For each PL, M counts up from M_MIN to M_MAX (default 1 to 255) with u = ref/M. If u < U_MIN (default 12,000), M stops counting and the next PL begins. If u > U_MAX (default 38,400), that M is skipped.
- R4: For an admitted M, N takes the values from floor(request·PL·M/ref) up to the matching ceiling. If that floor exceeds N_MAX, the next PL begins. Values below N_MIN are skipped, and values above N_MAX (default 255) end this M.
- R5: A candidate is used only when vco = floor(ref·N/M) lies within [VCO_MIN, VCO_MAX] (default 1,300,000 to 2,600,000 kHz). Its output is floor((vco + floor(PL/2))/PL), and its error is the absolute difference from the clamped request.
- R6: The kept triple changes only when a candidate has a strictly smaller error. The search ends at once when an error of zero is found. With `best_fit` = 1, no other condition ends it early.
- R7: With `best_fit` = 0, the search also ends right after a new best whose floor(vco/error) exceeds 218.
- R8: `freq_khz` = floor(ref·N/(M·PL)) for the returned triple.
- R9: If no candidate is accepted, `no_fit` = 1 and the outputs are M = M_MAX, N = N_MIN and PL = PL_MIN, with `freq_khz` computed from them. Otherwise `no_fit` = 0.
- R10: `busy` is high from the cycle after `start` is taken until `done`. `done` is a one-cycle pulse with `busy` low. A `start` while `busy` is ignored and yields no extra result.
- R11: After reset all outputs are 0. Result outputs change only in the cycle that `done` is high, and they hold until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, taken while idle |
| best_fit | input | 1 | 1 = exhaustive search, 0 = accept a close hit |
| ref_khz | input | FW | Reference frequency in kHz |
| target_khz | input | FW | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| m_div | output | MOW | Chosen input divider |
| n_mul | output | NOW | Chosen feedback multiplier |
| pl_div | output | POW | Chosen post divider |
| freq_khz | output | FW | Output frequency of the chosen triple |
| no_fit | output | 1 | No legal triple was found |

## Verification
The search length depends on the data, so no result has a fixed due cycle. Each result is due in the cycle that `done` is high, which is one register stage after the final division. `busy` is due one cycle after `start` is sampled. The checker samples on the falling edge: `busy` is checked one cycle after start, and the triple, frequency and flag are compared only in a cycle where `done` is high. The outputs are compared again four cycles later to confirm they hold. Each expected result comes from an independent model of the search, which is pushed into a queue before `start` is driven. A `done` that arrives with an empty queue is counted as a failure.

// File: rtl/pcs_pkg.sv
// Package: shared types of the divider coefficient search engine.
// Assumes: nothing; holds only the controller state encoding.
package pcs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,   // waiting for a request
        S_TV,     // oscillator goal slack division
        S_HI,     // upper post divider bound
        S_LO,     // lower post divider bound
        S_PL,     // post divider loop head
        S_MT,     // input divider loop head
        S_MU,     // divided reference
        S_MN,     // feedback floor
        S_NC,     // feedback loop head
        S_NV,     // oscillator of candidate
        S_NL,     // rounded output of candidate
        S_NR,     // closeness ratio
        S_FQ      // achieved frequency
    } pcs_state_t;

endpackage

// File: rtl/pcs_divider.sv
// Module: pcs_divider
// Restoring unsigned divider. It produces one quotient bit per cycle and
// pulses done exactly DW cycles after start.
// Assumes: start is only raised while no division is running, or it is
// acceptable that the new start aborts the running one. A zero divisor
// returns an all-ones quotient and is not treated as an error.
module pcs_divider #(
    parameter int DW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] dsr;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   trial;
    logic [DW:0]   diff;

    // Partial remainder shifted left with the next dividend bit.
    always_comb begin
        trial = {rem, quo[DW-1]};
        diff  = trial - {1'b0, dsr};
    end

    // One restoring step per cycle while a division is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsr  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
            quo  <= '0;
            rem  <= '0;
        end else if (start) begin
            dsr  <= divisor;
            quo  <= dividend;
            rem  <= '0;
            cnt  <= CW'(DW);
            run  <= 1'b1;
            done <= 1'b0;
        end else if (run) begin
            if (!diff[DW]) begin
                rem <= diff[DW-1:0];
                quo <= {quo[DW-2:0], 1'b1};
            end else begin
                rem <= trial[DW-1:0];
                quo <= {quo[DW-2:0], 1'b0};
            end
            cnt  <= cnt - 1'b1;
            run  <= (cnt != CW'(1));
            done <= (cnt == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    // R8: a finished division leaves a remainder below a nonzero divisor
    a_r8_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dsr != '0) |-> (rem < dsr));

    // R10: a result strobe is never followed by a second one
    a_r10_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pcs_ctrl.sv
// Module: pcs_ctrl
// Sequencer of the coefficient search. It clamps the request, derives the
// post divider bounds and walks the post divider, input divider and feedback
// loops with pruning. It keeps the best candidate and, at the end, computes
// the achieved frequency. Every quotient comes from the external divider
// through a go/done pair.
// Assumes: the divider pulses div_done once per div_go, and ref_khz is
// nonzero.
module pcs_ctrl
    import pcs_pkg::*;
#(
    parameter int FW        = 22,
    parameter int DW        = 40,
    parameter int F_MIN     = 128000,
    parameter int F_MAX     = 2600000,
    parameter int VCO_MIN   = 1300000,
    parameter int VCO_MAX   = 2600000,
    parameter int U_MIN     = 12000,
    parameter int U_MAX     = 38400,
    parameter int M_MIN     = 1,
    parameter int M_MAX     = 255,
    parameter int N_MIN     = 8,
    parameter int N_MAX     = 255,
    parameter int PL_MIN    = 1,
    parameter int PL_MAX    = 31,
    parameter int SLACK_DIV = 50,
    parameter int FIT_RATIO = 218,
    parameter int MOW       = $clog2(M_MAX + 1),
    parameter int NOW       = $clog2(N_MAX + 1),
    parameter int POW       = $clog2(PL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           best_fit,
    input  logic [FW-1:0]  ref_khz,
    input  logic [FW-1:0]  target_khz,
    output logic           div_go,
    output logic [DW-1:0]  div_a,
    output logic [DW-1:0]  div_b,
    input  logic           div_done,
    input  logic [DW-1:0]  div_q,
    input  logic [DW-1:0]  div_r,
    output logic           busy,
    output logic           done,
    output logic [MOW-1:0] m_div,
    output logic [NOW-1:0] n_mul,
    output logic [POW-1:0] pl_div,
    output logic [FW-1:0]  freq_khz,
    output logic           no_fit
);
    localparam logic [DW-1:0] W_FMIN  = DW'(F_MIN);
    localparam logic [DW-1:0] W_FMAX  = DW'(F_MAX);
    localparam logic [DW-1:0] W_VMIN  = DW'(VCO_MIN);
    localparam logic [DW-1:0] W_VMAX  = DW'(VCO_MAX);
    localparam logic [DW-1:0] W_UMIN  = DW'(U_MIN);
    localparam logic [DW-1:0] W_UMAX  = DW'(U_MAX);
    localparam logic [DW-1:0] W_MMIN  = DW'(M_MIN);
    localparam logic [DW-1:0] W_MMAX  = DW'(M_MAX);
    localparam logic [DW-1:0] W_NMIN  = DW'(N_MIN);
    localparam logic [DW-1:0] W_NMAX  = DW'(N_MAX);
    localparam logic [DW-1:0] W_PMIN  = DW'(PL_MIN);
    localparam logic [DW-1:0] W_PMAX  = DW'(PL_MAX);
    localparam logic [DW-1:0] W_SLACK = DW'(SLACK_DIV);
    localparam logic [DW-1:0] W_RATIO = DW'(FIT_RATIO);

    pcs_state_t    st;
    logic          issued;
    logic          bf_r;
    logic          found;
    logic [DW-1:0] t_r, ref_r, tv_r, hi_r, pl_r, m_r, n_r, n2_r;
    logic [DW-1:0] tvco_r, vco_r, dlt_r, best_d;
    logic [MOW-1:0] bm;
    logic [NOW-1:0] bn;
    logic [POW-1:0] bp;

    logic          is_div_st;
    logic          fin;
    logic [DW-1:0] tgt_in, tgt_clamped, vceil, dcur, q_pl;

    // Request clamp and the per-step helper values.
    always_comb begin
        tgt_in      = DW'(target_khz);
        tgt_clamped = (tgt_in > W_FMAX) ? W_FMAX :
                      (tgt_in < W_FMIN) ? W_FMIN : tgt_in;
        vceil       = (tv_r > W_VMAX) ? tv_r : W_VMAX;
        dcur        = (div_q >= t_r) ? (div_q - t_r) : (t_r - div_q);
        q_pl        = (div_q < W_PMIN) ? W_PMIN :
                      (div_q > W_PMAX) ? W_PMAX : div_q;
    end

    // States that wait on the shared divider.
    always_comb begin
        is_div_st = (st == S_TV) || (st == S_HI) || (st == S_LO) ||
                    (st == S_MU) || (st == S_MN) || (st == S_NV) ||
                    (st == S_NL) || (st == S_NR) || (st == S_FQ);
        div_go    = is_div_st && !issued;
        fin       = is_div_st && issued && div_done;
    end

    // Operand selection for the divider per state.
    always_comb begin
        div_a = '0;
        div_b = DW'(1);
        case (st)
            S_TV: begin div_a = t_r;                        div_b = W_SLACK; end
            S_HI: begin div_a = vceil + tv_r - DW'(1);      div_b = tv_r;    end
            S_LO: begin div_a = W_VMIN;                     div_b = tv_r;    end
            S_MU: begin div_a = ref_r;                      div_b = m_r;     end
            S_MN: begin div_a = tvco_r * m_r;               div_b = ref_r;   end
            S_NV: begin div_a = ref_r * n_r;                div_b = m_r;     end
            S_NL: begin div_a = vco_r + (pl_r >> 1);        div_b = pl_r;    end
            S_NR: begin div_a = vco_r;                      div_b = dlt_r;   end
            S_FQ: begin div_a = ref_r * DW'(bn);
                        div_b = DW'(bm) * DW'(bp);                           end
            default: ;
        endcase
    end

    // Search sequencer: loop control, best tracking and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            issued   <= 1'b0;
            bf_r     <= 1'b0;
            found    <= 1'b0;
            t_r      <= '0;
            ref_r    <= '0;
            tv_r     <= '0;
            hi_r     <= '0;
            pl_r     <= '0;
            m_r      <= '0;
            n_r      <= '0;
            n2_r     <= '0;
            tvco_r   <= '0;
            vco_r    <= '0;
            dlt_r    <= '0;
            best_d   <= '1;
            bm       <= '0;
            bn       <= '0;
            bp       <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            m_div    <= '0;
            n_mul    <= '0;
            pl_div   <= '0;
            freq_khz <= '0;
            no_fit   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (div_go) begin
                issued <= 1'b1;
            end else if (fin) begin
                issued <= 1'b0;
            end
            case (st)
                S_IDLE: if (start) begin
                    t_r    <= tgt_clamped;
                    ref_r  <= DW'(ref_khz);
                    bf_r   <= best_fit;
                    found  <= 1'b0;
                    best_d <= '1;
                    bm     <= MOW'(M_MAX);
                    bn     <= NOW'(N_MIN);
                    bp     <= POW'(PL_MIN);
                    busy   <= 1'b1;
                    st     <= S_TV;
                end
                S_TV: if (fin) begin
                    tv_r <= t_r + div_q;
                    st   <= S_HI;
                end
                S_HI: if (fin) begin
                    hi_r <= q_pl;
                    st   <= S_LO;
                end
                S_LO: if (fin) begin
                    pl_r <= q_pl;
                    st   <= S_PL;
                end
                S_PL: begin
                    if (pl_r > hi_r) begin
                        st <= S_FQ;
                    end else begin
                        tvco_r <= t_r * pl_r;
                        m_r    <= W_MMIN;
                        st     <= S_MT;
                    end
                end
                S_MT: begin
                    if (m_r > W_MMAX) begin
                        pl_r <= pl_r + DW'(1);
                        st   <= S_PL;
                    end else begin
                        st <= S_MU;
                    end
                end
                S_MU: if (fin) begin
                    if (div_q < W_UMIN) begin
                        pl_r <= pl_r + DW'(1);
                        st   <= S_PL;
                    end else if (div_q > W_UMAX) begin
                        m_r <= m_r + DW'(1);
                        st  <= S_MT;
                    end else begin
                        st <= S_MN;
                    end
                end
                S_MN: if (fin) begin
                    if (div_q > W_NMAX) begin
                        pl_r <= pl_r + DW'(1);
                        st   <= S_PL;
                    end else begin
                        n_r  <= div_q;
                        n2_r <= div_q + DW'(div_r != '0);
                        st   <= S_NC;
                    end
                end
                S_NC: begin
                    if (n_r > n2_r || n_r > W_NMAX) begin
                        m_r <= m_r + DW'(1);
                        st  <= S_MT;
                    end else if (n_r < W_NMIN) begin
                        n_r <= n_r + DW'(1);
                    end else begin
                        st <= S_NV;
                    end
                end
                S_NV: if (fin) begin
                    vco_r <= div_q;
                    if (div_q >= W_VMIN && div_q <= W_VMAX) begin
                        st <= S_NL;
                    end else begin
                        n_r <= n_r + DW'(1);
                        st  <= S_NC;
                    end
                end
                S_NL: if (fin) begin
                    if (dcur < best_d) begin
                        best_d <= dcur;
                        found  <= 1'b1;
                        bm     <= m_r[MOW-1:0];
                        bn     <= n_r[NOW-1:0];
                        bp     <= pl_r[POW-1:0];
                        if (dcur == '0) begin
                            st <= S_FQ;
                        end else if (!bf_r) begin
                            dlt_r <= dcur;
                            st    <= S_NR;
                        end else begin
                            n_r <= n_r + DW'(1);
                            st  <= S_NC;
                        end
                    end else begin
                        n_r <= n_r + DW'(1);
                        st  <= S_NC;
                    end
                end
                S_NR: if (fin) begin
                    if (div_q > W_RATIO) begin
                        st <= S_FQ;
                    end else begin
                        n_r <= n_r + DW'(1);
                        st  <= S_NC;
                    end
                end
                S_FQ: if (fin) begin
                    freq_khz <= div_q[FW-1:0];
                    m_div    <= bm;
                    n_mul    <= bn;
                    pl_div   <= bp;
                    no_fit   <= !found;
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    st       <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R1: the working request always lies inside the output range
    a_r1_request_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st != S_TV) |-> (t_r >= W_FMIN && t_r <= W_FMAX));

    // R6: the kept error never grows during a search
    a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_d <= $past(best_d)));

    // R9: a failed search returns the default triple
    a_r9_fail_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_fit) |-> (m_div == MOW'(M_MAX) && n_mul == NOW'(N_MIN) &&
                              pl_div == POW'(PL_MIN)));

    // R4: an accepted multiplier lies inside its range
    a_r4_n_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (n_mul >= NOW'(N_MIN) && n_mul <= NOW'(N_MAX)));

    // R10: busy ends only through a result strobe, never beside it
    a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: result outputs move only with a result strobe
    a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(m_div) && $stable(n_mul) && $stable(pl_div) &&
                   $stable(freq_khz) && $stable(no_fit)));

endmodule

// File: rtl/pll_coef_search.sv
// Module: pll_coef_search
// Top of the divider coefficient search engine: the search sequencer plus
// one shared restoring divider.
// Assumes: a single clock domain; requests arrive as one-cycle pulses.
module pll_coef_search #(
    parameter int FW        = 22,
    parameter int DW        = 40,
    parameter int F_MIN     = 128000,
    parameter int F_MAX     = 2600000,
    parameter int VCO_MIN   = 1300000,
    parameter int VCO_MAX   = 2600000,
    parameter int U_MIN     = 12000,
    parameter int U_MAX     = 38400,
    parameter int M_MIN     = 1,
    parameter int M_MAX     = 255,
    parameter int N_MIN     = 8,
    parameter int N_MAX     = 255,
    parameter int PL_MIN    = 1,
    parameter int PL_MAX    = 31,
    parameter int SLACK_DIV = 50,
    parameter int FIT_RATIO = 218,
    parameter int MOW       = $clog2(M_MAX + 1),
    parameter int NOW       = $clog2(N_MAX + 1),
    parameter int POW       = $clog2(PL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           best_fit,
    input  logic [FW-1:0]  ref_khz,
    input  logic [FW-1:0]  target_khz,
    output logic           busy,
    output logic           done,
    output logic [MOW-1:0] m_div,
    output logic [NOW-1:0] n_mul,
    output logic [POW-1:0] pl_div,
    output logic [FW-1:0]  freq_khz,
    output logic           no_fit
);
    logic          div_go;
    logic          div_done;
    logic [DW-1:0] div_a, div_b, div_q, div_r;

    pcs_ctrl #(
        .FW(FW), .DW(DW), .F_MIN(F_MIN), .F_MAX(F_MAX),
        .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX), .U_MIN(U_MIN), .U_MAX(U_MAX),
        .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX),
        .PL_MIN(PL_MIN), .PL_MAX(PL_MAX), .SLACK_DIV(SLACK_DIV),
        .FIT_RATIO(FIT_RATIO), .MOW(MOW), .NOW(NOW), .POW(POW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .best_fit(best_fit),
        .ref_khz(ref_khz), .target_khz(target_khz),
        .div_go(div_go), .div_a(div_a), .div_b(div_b),
        .div_done(div_done), .div_q(div_q), .div_r(div_r),
        .busy(busy), .done(done), .m_div(m_div), .n_mul(n_mul),
        .pl_div(pl_div), .freq_khz(freq_khz), .no_fit(no_fit)
    );

    pcs_divider #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_go),
        .dividend(div_a), .divisor(div_b),
        .done(div_done), .quo(div_q), .rem(div_r)
    );

endmodule

// File: tb/pll_coef_search_tb.sv
module pll_coef_search_tb;
    localparam int FW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          best_fit = 1'b0;
    logic [FW-1:0] ref_khz = '0;
    logic [FW-1:0] target_khz = '0;
    logic          busy, done, no_fit;
    logic [7:0]    m_div, n_mul;
    logic [4:0]    pl_div;
    logic [FW-1:0] freq_khz;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        longint m;
        longint n;
        longint pl;
        longint f;
        bit     err;
    } exp_t;

    exp_t sb[$];
    exp_t last;

    pll_coef_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .best_fit(best_fit),
        .ref_khz(ref_khz), .target_khz(target_khz), .busy(busy), .done(done),
        .m_div(m_div), .n_mul(n_mul), .pl_div(pl_div), .freq_khz(freq_khz),
        .no_fit(no_fit)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent model of the search, written from the requirements.
    function automatic exp_t model(input longint rf, input longint tg, input bit bf);
        exp_t e;
        longint t, tv, vceil, hi, lo, tvc, u, n, n2, vco, lwv, d, bestd;
        bit found, stop;
        t = tg;
        if (t > 2600000) t = 2600000;                  // R1
        if (t < 128000) t = 128000;
        tv = t + t / 50;                               // R2
        vceil = (tv > 2600000) ? tv : 2600000;
        hi = (vceil + tv - 1) / tv;
        if (hi < 1) hi = 1;
        if (hi > 31) hi = 31;
        lo = 1300000 / tv;
        if (lo < 1) lo = 1;
        if (lo > 31) lo = 31;
        e.m = 255; e.n = 8; e.pl = 1;
        found = 0; stop = 0; bestd = 0;
        for (longint pl = lo; pl <= hi && !stop; pl++) begin
            tvc = t * pl;
            for (longint m = 1; m <= 255 && !stop; m++) begin
                u = rf / m;                            // R3
                if (u < 12000) break;
                if (u > 38400) continue;
                n = (tvc * m) / rf;                    // R4
                n2 = (tvc * m + rf - 1) / rf;
                if (n > 255) break;
                for (; n <= n2 && !stop; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = rf * n / m;                  // R5
                    if (vco >= 1300000 && vco <= 2600000) begin
                        lwv = (vco + pl / 2) / pl;
                        d = (lwv >= t) ? lwv - t : t - lwv;
                        if (!found || d < bestd) begin // R6
                            found = 1; bestd = d;
                            e.m = m; e.n = n; e.pl = pl;
                            if (d == 0 || (!bf && vco / d > 218)) stop = 1; // R7
                        end
                    end
                end
            end
        end
        e.f = (rf * e.n / (e.m * e.pl)) % (64'd1 << FW); // R8
        e.err = !found;                                // R9
        return e;
    endfunction

    // Driver: push the expected item, issue the request, optionally poke
    // start while busy, wait for the scoreboard to drain, then check hold.
    task automatic run_case(input longint rf, input longint tg, input bit bf,
                            input bit poke, input string tag);
        exp_t e;
        e = model(rf, tg, bf);
        sb.push_back(e);
        @(negedge clk);
        ref_khz = FW'(rf);
        target_khz = FW'(tg);
        best_fit = bf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, {"R10 busy after start ", tag}, busy, 1);
        if (poke) begin
            @(negedge clk);
            target_khz = FW'(777777);
            best_fit = ~bf;
            start = 1'b1;           // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        last = e;
        repeat (4) @(negedge clk);
        check(!done, {"R10 no extra result ", tag}, done, 0);
        check(m_div == 8'(last.m) && n_mul == 8'(last.n) && pl_div == 5'(last.pl)
              && freq_khz == FW'(last.f) && no_fit == last.err,
              {"R11 results hold ", tag}, freq_khz, last.f);
    endtask

    // Monitor: compare each strobed result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(0, "R10 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(!busy, "R10 busy low at done", busy, 0);
                check(m_div == 8'(e.m), "R3 M", m_div, e.m);
                check(n_mul == 8'(e.n), "R4 N", n_mul, e.n);
                check(pl_div == 5'(e.pl), "R2 PL", pl_div, e.pl);
                check(freq_khz == FW'(e.f), "R8 freq", freq_khz, e.f);
                check(no_fit == e.err, "R9 no_fit", no_fit, e.err);
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(!busy && !done, "R11 reset busy/done", busy, 0);
        check(m_div == 0 && n_mul == 0 && pl_div == 0, "R11 reset triple", m_div, 0);
        check(freq_khz == 0 && !no_fit, "R11 reset freq/flag", freq_khz, 0);

        run_case(38400, 1000000, 1'b1, 1'b0, "R5 R6 exhaustive 1GHz");
        run_case(38400, 1234567, 1'b0, 1'b1, "R7 relaxed with ignored start");
        run_case(38400, 1234567, 1'b1, 1'b0, "R6 exhaustive same request");
        run_case(19200, 3000000, 1'b1, 1'b0, "R1 clamp high");
        run_case(12000, 100000, 1'b1, 1'b0, "R1 R2 clamp low wide PL range");
        run_case(5000, 1000000, 1'b1, 1'b0, "R9 reference too slow");
        run_case(19200, 700001, 1'b0, 1'b0, "R3 R4 relaxed odd target");
        run_case(38400, 2600000, 1'b0, 1'b0, "R2 top of range");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule